// File: doc/BRIEF.md
# Half-Duplex Converter Serial Port

This block is the slave-side serial interface of a two-channel sampling converter. A host lowers an active-low select, toggles a serial clock, and sends a configuration word on a data-in line. The port answers on a data-out line that has its own output enable. Each exchange runs in four steps. The port hunts for a start bit. It then takes in a 3-bit configuration word and latches a 12-bit sample from the selected parallel channel input. Last, it drives a single low null bit followed by the sample. The sample goes out first from the top bit down, then again from bit 1 upward, and zeros after that.

The data-out line stays undriven while the host is still sending. This lets data-in and data-out share one wire for a three-wire hookup. The serial clock and select are oversampled by a faster system clock. Both pass through synchronizers and edge detectors, so all state lives in one clock domain. A one-cycle pulse marks the moment the last configuration bit arrives, which is when a conversion would start. The selected channel number is exposed as an output.

Top module: `adc_serial_port`

## Requirements
- R1: While reset is applied and just after it is released, dout_oe, dout, conv_start and chan_sel are all 0.
- R2: Raising cs_n returns the port to idle at any point in an exchange. dout_oe is 0 no more than SYNC_STAGES+3 system clocks after the rise. A fresh falling edge of cs_n is needed to begin again.
- R3: din is sampled only on rising sclk edges, so pulses on din while sclk is high are not seen. dout changes only after a falling sclk edge or a release of cs_n.
- R4: After cs_n falls, din samples of 0 are ignored until a 1 (the start bit) is sampled.
- R5: The 3 bits sampled after the start bit form the configuration word, and the first one received is word bit 2. Sampling the third bit produces exactly one conv_start pulse, one system clock wide, per exchange.
- R6: Configuration bit 0 (the last one received) selects the channel: 0 takes ch0_data and 1 takes ch1_data. chan_sel shows the selected channel. Bits 2 and 1 do not alter the output.
- R7: dout_oe stays 0 through the start bit and all configuration bits. It first becomes 1 after the first falling sclk edge that follows the last configuration bit.
- R8: The first driven output bit is a null bit of value 0. The 12 sample bits follow, bit 11 first and bit 0 last.
- R9: If clocks continue with cs_n low, the port next sends sample bits 1 through 11 in rising order.
- R10: After the bit-first repeat, every further output bit is 0 for as long as clocks continue.
- R11: The sample is registered when the last configuration bit is taken in. Later changes on ch0_data or ch1_data do not change the bits sent in that exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than sclk |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host (asynchronous) |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| din | input | 1 | Serial data from the host |
| ch0_data | input | 12 | Parallel conversion result of channel 0 |
| ch1_data | input | 12 | Parallel conversion result of channel 1 |
| dout | output | 1 | Serial data value toward the host |
| dout_oe | output | 1 | Drive enable for dout (0 means high impedance) |
| conv_start | output | 1 | One-cycle pulse when the configuration word is complete |
| chan_sel | output | 1 | Channel chosen by the last configuration |

## Verification
The hardest points to reach are deep in one exchange. One is the boundary between the bit-first repeat and the trailing zeros, which needs more than 24 serial clocks with select held low. The other is a select release in the middle of the configuration word. The stimulus holds select low through 30 output clocks so that every index of the output sequence is compared. It drops select after a single configuration bit and again after a few output bits, and then runs a clean exchange to show the port recovered. It also pulses din while sclk is high during the start hunt and changes both channel inputs straight after the capture point.

// File: rtl/adc_sp_pkg.sv
// Package: shared types for the half-duplex converter serial port.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package adc_sp_pkg;

    // Receive-side phase of one exchange.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // select high or no falling edge seen yet
        PH_HUNT  = 2'd1,   // waiting for the start bit
        PH_CFG   = 2'd2,   // shifting in the configuration word
        PH_XMIT  = 2'd3    // configuration done, output side owns the line
    } rx_phase_t;

endpackage

// File: rtl/adc_sp_sync.sv
// Module: adc_sp_sync
// Brings N asynchronous inputs into the clk domain through a chain of
// STAGES flops each, then flags rising and falling edges of the result.
// Assumes: each input stays stable for more than STAGES+1 clk cycles
// between changes, so no edge is lost.
module adc_sp_sync #(
    parameter int          N         = 3,
    parameter int          STAGES    = 2,
    parameter logic [N-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_chain
        logic [STAGES-1:0] chain_q;

        // Shift the raw input through the metastability chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RESET_VAL[g]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[g]};
            end
        end

        assign sync_out[g] = chain_q[STAGES-1];
    end

    // Hold the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RESET_VAL;
        end else begin
            prev_q <= sync_out;
        end
    end

    assign rise = sync_out & ~prev_q;
    assign fall = ~sync_out & prev_q;

endmodule

// File: rtl/adc_sp_rx.sv
// Module: adc_sp_rx
// Receive sequencer: waits for a select falling edge, hunts for a start
// bit, counts CFG_BITS configuration bits sampled on sclk rising edges and
// reports completion together with the last (channel) bit.
// Assumes: all inputs are already in the clk domain; cs_high is the level
// of the synchronized select and overrides everything else.
module adc_sp_rx
    import adc_sp_pkg::*;
#(
    parameter int CFG_BITS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_high,
    input  logic cs_fall,
    input  logic sclk_rise,
    input  logic din_s,
    output logic cfg_done,
    output logic chan_bit,
    output logic in_xmit
);

    localparam int CNT_W = (CFG_BITS > 1) ? $clog2(CFG_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CFG_BITS - 1);

    rx_phase_t        phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_bit;

    // The final configuration bit is being sampled this cycle.
    always_comb begin
        last_bit = (phase_q == PH_CFG) && sclk_rise && (cnt_q == LAST_IDX);
    end

    // Phase and bit-count register of the receive side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (cs_high) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (cs_fall) begin
                        phase_q <= PH_HUNT;
                    end
                end
                PH_HUNT: begin
                    if (sclk_rise && din_s) begin
                        phase_q <= PH_CFG;
                        cnt_q   <= '0;
                    end
                end
                PH_CFG: begin
                    if (last_bit) begin
                        phase_q <= PH_XMIT;
                    end else if (sclk_rise) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_XMIT;
                end
            endcase
        end
    end

    assign cfg_done = last_bit;
    assign chan_bit = din_s;
    assign in_xmit  = (phase_q == PH_XMIT);

endmodule

// File: rtl/adc_sp_tx.sv
// Module: adc_sp_tx
// Output sequencer: on each sclk falling edge while enabled, steps an index
// through null bit, MSB-first word, LSB-first repeat from bit 1, then zeros.
// Assumes: sample is stable while in_xmit is high; cs_high clears output.
module adc_sp_tx #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_high,
    input  logic         in_xmit,
    input  logic         sclk_fall,
    input  logic [W-1:0] sample,
    output logic         dout,
    output logic         dout_oe
);

    // Index 0 is the null bit, 1..W the MSB-first word, W+1..2W-1 the
    // bit-first repeat from bit 1, and 2W the saturating zero tail.
    localparam int             IDX_MAX_I = 2 * W;
    localparam int             IW        = $clog2(IDX_MAX_I + 1);
    localparam logic [IW-1:0]  IDX_MAX   = IW'(IDX_MAX_I);

    logic [IW-1:0] idx_q;
    logic [IW-1:0] idx_next;
    logic          started_q;

    // Bit value for a given output index.
    function automatic logic bit_at(input logic [W-1:0] s, input logic [IW-1:0] k);
        logic r;
        r = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (int'(k) == W - i) r = s[i];
            if ((i > 0) && (int'(k) == W + i)) r = s[i];
        end
        return r;
    endfunction

    // Next index: start at the null bit, then advance and saturate.
    always_comb begin
        if (!started_q) begin
            idx_next = '0;
        end else if (idx_q == IDX_MAX) begin
            idx_next = idx_q;
        end else begin
            idx_next = idx_q + 1'b1;
        end
    end

    // Drive the line only after falling sclk edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            started_q <= 1'b0;
            dout      <= 1'b0;
            dout_oe   <= 1'b0;
        end else if (cs_high || !in_xmit) begin
            idx_q     <= '0;
            started_q <= 1'b0;
            dout      <= 1'b0;
            dout_oe   <= 1'b0;
        end else if (sclk_fall) begin
            idx_q     <= idx_next;
            started_q <= 1'b1;
            dout      <= bit_at(sample, idx_next);
            dout_oe   <= 1'b1;
        end
    end

endmodule

// File: rtl/adc_serial_port.sv
// Module: adc_serial_port (top)
// Slave serial port of a two-channel converter: synchronizes select, clock
// and data, runs the receive sequencer, captures the selected channel at
// the end of the configuration word and hands it to the output sequencer.
// Assumes: clk runs at least 2*(SYNC_STAGES+2) times faster than sclk.
module adc_serial_port #(
    parameter int RES_W       = 12,
    parameter int CFG_BITS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [RES_W-1:0] ch0_data,
    input  logic [RES_W-1:0] ch1_data,
    output logic             dout,
    output logic             dout_oe,
    output logic             conv_start,
    output logic             chan_sel
);

    localparam int SIG_N   = 3;
    localparam int IDX_CS  = 0;
    localparam int IDX_CLK = 1;
    localparam int IDX_DIN = 2;

    logic [SIG_N-1:0] raw_in;
    logic [SIG_N-1:0] s_lvl;
    logic [SIG_N-1:0] s_rise;
    logic [SIG_N-1:0] s_fall;

    logic             cs_s;
    logic             cs_fall;
    logic             sclk_rise;
    logic             sclk_fall;
    logic             din_s;

    logic             cfg_done;
    logic             chan_bit;
    logic             in_xmit;

    logic [RES_W-1:0] sample_q;
    logic             chan_q;
    logic             conv_q;

    assign raw_in[IDX_CS]  = cs_n;
    assign raw_in[IDX_CLK] = sclk;
    assign raw_in[IDX_DIN] = din;

    adc_sp_sync #(
        .N         (SIG_N),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b001)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    assign cs_s      = s_lvl[IDX_CS];
    assign cs_fall   = s_fall[IDX_CS];
    assign sclk_rise = s_rise[IDX_CLK];
    assign sclk_fall = s_fall[IDX_CLK];
    assign din_s     = s_lvl[IDX_DIN];

    adc_sp_rx #(
        .CFG_BITS (CFG_BITS)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_high   (cs_s),
        .cs_fall   (cs_fall),
        .sclk_rise (sclk_rise),
        .din_s     (din_s),
        .cfg_done  (cfg_done),
        .chan_bit  (chan_bit),
        .in_xmit   (in_xmit)
    );

    // Latch channel and sample when the last configuration bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            chan_q   <= 1'b0;
            conv_q   <= 1'b0;
        end else begin
            conv_q <= cfg_done;
            if (cfg_done) begin
                chan_q   <= chan_bit;
                sample_q <= chan_bit ? ch1_data : ch0_data;
            end
        end
    end

    adc_sp_tx #(
        .W (RES_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_high   (cs_s),
        .in_xmit   (in_xmit),
        .sclk_fall (sclk_fall),
        .sample    (sample_q),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    assign conv_start = conv_q;
    assign chan_sel   = chan_q;

endmodule

// File: rtl/adc_serial_port_checker.sv
// Module: adc_serial_port_checker
// Temporal checks on the serial port, bound into every instance of the top.
// Assumes: reset is synchronous and active low.
module adc_serial_port_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic sclk_fall,
    input logic conv_start,
    input logic dout,
    input logic dout_oe
);

    // R2: a synchronized release of select silences the line next cycle.
    a_r2_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !dout_oe);

    // R3: the data value moves only after a falling sclk or a release.
    a_r3_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> ($past(sclk_fall) || $past(cs_s)));

    // R5: the configuration pulse is one clock wide.
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R7: the line is still undriven when configuration completes.
    a_r7_quiet_at_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !dout_oe);

    // R7: the drive enable only turns on after a falling sclk.
    a_r7_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(sclk_fall));

endmodule

bind adc_serial_port adc_serial_port_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .sclk_fall  (sclk_fall),
    .conv_start (conv_start),
    .dout       (dout),
    .dout_oe    (dout_oe)
);

// File: tb/adc_serial_port_test.sv
// Bench for adc_serial_port: a driver task plays the host and queues the
// expected line state for each rising sclk; a monitor compares on the rise.
module adc_serial_port_test;

    localparam int HALF = 8;
    localparam int SYNC = 2;
    localparam int WD   = 200000;

    typedef struct {
        logic  oe;
        logic  d;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [11:0] ch0 = '0;
    logic [11:0] ch1 = '0;
    logic        dout;
    logic        dout_oe;
    logic        conv_start;
    logic        chan_sel;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   conv_cnt = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    adc_serial_port uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .din        (din),
        .ch0_data   (ch0),
        .ch1_data   (ch1),
        .dout       (dout),
        .dout_oe    (dout_oe),
        .conv_start (conv_start),
        .chan_sel   (chan_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input logic [11:0] s, input int k);
        if (k == 0) return 1'b0;
        if (k <= 12) return s[12 - k];
        if (k <= 23) return s[k - 12];
        return 1'b0;
    endfunction

    task automatic push(input logic oe, input logic d, input string tag);
        exp_t e;
        e.oe = oe;
        e.d = d;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // One serial clock period; optional din pulse while sclk is high.
    task automatic sclk_cycle(input bit glitch);
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        if (glitch) begin
            repeat (2) @(negedge clk);
            din = 1'b1;
            repeat (3) @(negedge clk);
            din = 1'b0;
            repeat (HALF - 5) @(negedge clk);
        end else begin
            repeat (HALF) @(negedge clk);
        end
        sclk = 1'b0;
    endtask

    // Monitor: compare the line against the queue on every rising sclk.
    always @(posedge sclk) begin
        exp_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "queue", 0, 1);
        end else begin
            e = exp_q.pop_front();
            chk(dout_oe == e.oe, {e.tag, " oe"}, int'(dout_oe), int'(e.oe));
            if (e.oe) chk(dout == e.d, {e.tag, " data"}, int'(dout), int'(e.d));
        end
    end

    always @(posedge clk) if (conv_start) conv_cnt++;

    task automatic release_cs();
        @(negedge clk) cs_n = 1'b1;
        repeat (SYNC + 3) @(negedge clk);
        chk(dout_oe == 1'b0, "R2 release", int'(dout_oe), 0);
        repeat (HALF) @(negedge clk);
    endtask

    // Driver: one full exchange.
    task automatic xfer(input logic [2:0] cfg, input int lead, input int nout,
                        input logic [11:0] c0, input logic [11:0] c1,
                        input bit disturb, input bit glitch);
        logic [11:0] s;
        int          c_before;
        string       tg;
        ch0 = c0;
        ch1 = c1;
        @(negedge clk) cs_n = 1'b0;
        c_before = conv_cnt;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < lead; i++) begin
            din = 1'b0;
            push(1'b0, 1'b0, glitch ? "R3" : "R4");
            sclk_cycle(glitch);
        end
        din = 1'b1;
        push(1'b0, 1'b0, "R7");
        sclk_cycle(1'b0);
        for (int i = 2; i >= 0; i--) begin
            din = cfg[i];
            push(1'b0, 1'b0, "R7");
            sclk_cycle(1'b0);
        end
        din = 1'b0;
        s = cfg[0] ? c1 : c0;
        if (disturb) begin
            ch0 = ~c0;
            ch1 = ~c1;
        end
        for (int k = 0; k < nout; k++) begin
            if (disturb) tg = "R11";
            else if (k <= 12) tg = "R8";
            else if (k <= 23) tg = "R9";
            else tg = "R10";
            push(1'b1, exp_bit(s, k), tg);
            sclk_cycle(1'b0);
        end
        chk(chan_sel == cfg[0], "R6 chan_sel", int'(chan_sel), int'(cfg[0]));
        chk(conv_cnt - c_before == 1, "R5 pulses", conv_cnt - c_before, 1);
        release_cs();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(dout_oe == 1'b0, "R1 oe", int'(dout_oe), 0);
        chk(dout == 1'b0, "R1 dout", int'(dout), 0);
        chk(conv_start == 1'b0, "R1 conv", int'(conv_start), 0);
        chk(chan_sel == 1'b0, "R1 chan", int'(chan_sel), 0);

        // R8: channel 0, MSB-first word only.
        xfer(3'b000, 0, 13, 12'hA5C, 12'h3F1, 1'b0, 1'b0);
        // R4 R9 R10 R6: leading zeros, channel 1, long tail.
        xfer(3'b101, 3, 30, 12'h0F0, 12'hB2D, 1'b0, 1'b0);
        // R3: din pulses while sclk high must not count as start bit.
        xfer(3'b001, 2, 14, 12'h123, 12'h9E7, 1'b0, 1'b1);
        // R6 R11: upper config bits set, channel 0, inputs change after capture.
        xfer(3'b110, 1, 25, 12'hC36, 12'h5A5, 1'b1, 1'b0);

        // R2: abort in the middle of the configuration word.
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        din = 1'b1;
        push(1'b0, 1'b0, "R2");
        sclk_cycle(1'b0);
        din = 1'b1;
        push(1'b0, 1'b0, "R2");
        sclk_cycle(1'b0);
        din = 1'b0;
        release_cs();

        // R2: abort after a few output bits, then a clean exchange.
        xfer(3'b011, 0, 5, 12'h777, 12'h8C1, 1'b0, 1'b0);
        xfer(3'b100, 0, 20, 12'hFFE, 12'h001, 1'b0, 1'b0);

        chk(exp_q.size() == 0, "queue drained", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule